// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Gap Timers and Byte Matching

This block recovers asynchronous serial characters from a single input line. The line is sampled on a one-clock enable pulse that runs at sixteen times the bit rate. Each character can carry 5 to 8 data bits, an optional odd or even parity bit, and one or two stop bits. The received data bits and two error bits are written together as one word into a first-word-fall-through queue. The queue is read through a simple pop strobe.

Two idle timers tell the consumer when a burst of traffic has ended. The first fires when the line has been quiet for a programmed number of sample ticks after the last character. The second fires when a programmed number of ticks has passed since the character that opened the current buffer. Four comparators, each with its own enable, raise a one-clock hit when a clean character equals their programmed value. A ready-to-send output gives the far transmitter hardware flow control. It follows the queue fill level with hysteresis.

Top module: `uart_rx_top`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_count is 0, rts is 1 and char_gap, buf_gap and match_hit are all 0.
- R2: A start is accepted only after the line, previously sampled high, is sampled low on a tick and is still low on the 8th tick counting that one as the 1st. A low pulse that is high again by then stores nothing.
- R3: Data bits arrive least significant first and are each taken at mid-bit (16 ticks apart). cfg_len 0, 1, 2, 3 selects 5, 6, 7, 8 data bits, and the unused upper bits of rd_data read 0.
- R4: cfg_par 0 means no parity bit, 1 means odd and 2 means even, counted over the data bits plus the parity bit. A mismatch stores the word with rd_perr = 1.
- R5: cfg_stop2 = 1 samples two stop bits and 0 samples one. If any sampled stop bit is low, the word is still stored, with rd_ferr = 1. A new start needs the line to return high first.
- R6: The queue holds 32 words in arrival order, and rd_data, rd_perr and rd_ferr always show the oldest word. A character that arrives while the queue holds 32 words is discarded.
- R7: rts goes to 0 the clock after fifo_count is 28 or more, and returns to 1 the clock after fifo_count is below 24. Between those levels it holds its value.
- R8: char_gap rises once cfg_cgap ticks have passed with the receiver idle since the last stored character, and clears on the next stored character.
- R9: buf_gap rises cfg_bgap ticks after the character that opened a buffer. Later characters in the same buffer do not restart this timer. The first character after buf_gap starts a new buffer and clears the flag.
- R10: match_hit[i] pulses for one clock, together with the store, when comparator i is enabled, the character has no parity or framing error, and its data equals byte i of cfg_match_val.
- R11: rd_en while the queue is empty has no effect: no word is lost and the count does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-clock pulse at 16x the bit rate |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | 0 none, 1 odd, 2 even |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_cgap | input | GAP_W | Idle-gap limit in ticks |
| cfg_bgap | input | GAP_W | Buffer-gap limit in ticks |
| cfg_match_en | input | N_MATCH | Per-comparator enable |
| cfg_match_val | input | 8*N_MATCH | Compare bytes, comparator i in bits 8i+7:8i |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 8 | Oldest word data |
| rd_perr | output | 1 | Oldest word parity error |
| rd_ferr | output | 1 | Oldest word framing error |
| fifo_empty | output | 1 | Queue empty |
| fifo_count | output | CNT_W | Words held |
| rts | output | 1 | Ready-to-send to far end |
| char_gap | output | 1 | Idle gap after last character |
| buf_gap | output | 1 | Buffer time elapsed |
| match_hit | output | N_MATCH | Per-comparator hit pulse |

## Verification
The properties assume that tick16 is a single-clock pulse with idle clocks between pulses. They also assume the configuration inputs do not change while a character is in flight. The match property in particular relies on cfg_match_en being steady around each store. The bench writes every configuration field only while the line is idle, with all earlier characters complete. It drives the line only between tick edges, so every bit spans exactly sixteen ticks. rd_en is raised for one clock at a time, including deliberate pops of an empty queue.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2
    } par_mode_e;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PBIT,
        FR_STOPA,
        FR_STOPB
    } fr_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    function automatic logic [3:0] data_bits(input logic [1:0] sel);
        return 4'(sel) + 4'd5;
    endfunction

endpackage

// File: rtl/urx_framer.sv
module urx_framer
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic [1:0] par_sel,
    input  logic       stop2,
    output logic       busy,
    output logic       wr,
    output rx_word_t   word
);
    fr_state_e  st;
    logic [3:0] cnt;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic       pbit;
    logic       ferr_a;
    logic       prev;

    logic [3:0] nb;
    logic [7:0] aligned;
    logic       perr_now;
    par_mode_e  pm;

    always_comb begin
        pm       = par_mode_e'(par_sel);
        nb       = data_bits(len_sel);
        aligned  = shreg >> (4'd8 - nb);
        perr_now = (pm == PAR_NONE) ? 1'b0
                 : ((^aligned ^ pbit) != (pm == PAR_ODD));
        busy     = (st != FR_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FR_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            ferr_a <= 1'b0;
            prev   <= 1'b1;
            wr     <= 1'b0;
            word   <= '0;
        end else begin
            wr <= 1'b0;
            if (tick) begin
                prev <= rxd;
                case (st)
                    FR_IDLE: begin
                        if (prev && !rxd) begin
                            st  <= FR_START;
                            cnt <= '0;
                        end
                    end
                    FR_START: begin
                        if (cnt == 4'd6) begin
                            if (rxd) begin
                                st <= FR_IDLE;
                            end else begin
                                st     <= FR_DATA;
                                cnt    <= '0;
                                bitn   <= '0;
                                shreg  <= '0;
                                pbit   <= 1'b0;
                                ferr_a <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    default: begin
                        if (cnt != 4'd15) begin
                            cnt <= cnt + 4'd1;
                        end else begin
                            cnt <= '0;
                            case (st)
                                FR_DATA: begin
                                    shreg <= {rxd, shreg[7:1]};
                                    bitn  <= bitn + 4'd1;
                                    if (bitn == nb - 4'd1)
                                        st <= (pm == PAR_NONE) ? FR_STOPA : FR_PBIT;
                                end
                                FR_PBIT: begin
                                    pbit <= rxd;
                                    st   <= FR_STOPA;
                                end
                                FR_STOPA: begin
                                    if (stop2) begin
                                        ferr_a <= !rxd;
                                        st     <= FR_STOPB;
                                    end else begin
                                        wr        <= 1'b1;
                                        word.data <= aligned;
                                        word.perr <= perr_now;
                                        word.ferr <= !rxd;
                                        st        <= FR_IDLE;
                                    end
                                end
                                default: begin
                                    wr        <= 1'b1;
                                    word.data <= aligned;
                                    word.perr <= perr_now;
                                    word.ferr <= ferr_a | !rxd;
                                    st        <= FR_IDLE;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  rx_word_t      wdata,
    input  logic          rd,
    output rx_word_t      rdata,
    output logic [CW-1:0] count,
    output logic          empty
);
    rx_word_t      mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_wr;
    logic          do_rd;

    always_comb begin
        empty = (count == '0);
        do_wr = wr && (count != CW'(DEPTH));
        do_rd = rd && !empty;
        rdata = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= wptr + AW'(1);
            if (do_rd) rptr <= rptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/urx_gap_timer.sv
module urx_gap_timer #(
    parameter int GW          = 16,
    parameter bit RESTART_ALL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          busy,
    input  logic          wr,
    input  logic [GW-1:0] lim,
    output logic          flag
);
    logic          run;
    logic [GW-1:0] cnt;
    logic          step;
    logic [GW:0]   nxt;

    always_comb begin
        step = run && tick && (RESTART_ALL ? !busy : 1'b1);
        nxt  = {1'b0, cnt} + (GW+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            cnt  <= '0;
            flag <= 1'b0;
        end else if (wr) begin
            flag <= 1'b0;
            run  <= 1'b1;
            if (RESTART_ALL || !run) cnt <= '0;
        end else if (step) begin
            if (nxt >= {1'b0, lim}) begin
                flag <= 1'b1;
                run  <= 1'b0;
            end else begin
                cnt <= nxt[GW-1:0];
            end
        end
    end

endmodule

// File: rtl/urx_match.sv
module urx_match
    import urx_pkg::*;
#(
    parameter int NM = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  rx_word_t        word,
    input  logic [NM-1:0]   en,
    input  logic [NM*8-1:0] vals,
    output logic [NM-1:0]   hit
);
    logic clean;
    assign clean = wr && !word.perr && !word.ferr;

    for (genvar i = 0; i < NM; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) hit[i] <= 1'b0;
            else     hit[i] <= clean && en[i] && (word.data == vals[i*8 +: 8]);
        end
    end

endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import urx_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int RTS_OFF = 28,
    parameter int RTS_ON  = 24,
    parameter int GAP_W   = 16,
    parameter int N_MATCH = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic                 tick16,
    input  logic [1:0]           cfg_len,
    input  logic [1:0]           cfg_par,
    input  logic                 cfg_stop2,
    input  logic [GAP_W-1:0]     cfg_cgap,
    input  logic [GAP_W-1:0]     cfg_bgap,
    input  logic [N_MATCH-1:0]   cfg_match_en,
    input  logic [N_MATCH*8-1:0] cfg_match_val,
    input  logic                 rd_en,
    output logic [7:0]           rd_data,
    output logic                 rd_perr,
    output logic                 rd_ferr,
    output logic                 fifo_empty,
    output logic [CNT_W-1:0]     fifo_count,
    output logic                 rts,
    output logic                 char_gap,
    output logic                 buf_gap,
    output logic [N_MATCH-1:0]   match_hit
);
    logic     busy;
    logic     wr;
    rx_word_t word;
    rx_word_t head;

    urx_framer u_framer (
        .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd),
        .len_sel(cfg_len), .par_sel(cfg_par), .stop2(cfg_stop2),
        .busy(busy), .wr(wr), .word(word)
    );

    urx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr(wr), .wdata(word), .rd(rd_en),
        .rdata(head), .count(fifo_count), .empty(fifo_empty)
    );

    urx_gap_timer #(.GW(GAP_W), .RESTART_ALL(1'b1)) u_cgap (
        .clk(clk), .rst(rst), .tick(tick16), .busy(busy), .wr(wr),
        .lim(cfg_cgap), .flag(char_gap)
    );

    urx_gap_timer #(.GW(GAP_W), .RESTART_ALL(1'b0)) u_bgap (
        .clk(clk), .rst(rst), .tick(tick16), .busy(busy), .wr(wr),
        .lim(cfg_bgap), .flag(buf_gap)
    );

    urx_match #(.NM(N_MATCH)) u_match (
        .clk(clk), .rst(rst), .wr(wr), .word(word),
        .en(cfg_match_en), .vals(cfg_match_val), .hit(match_hit)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;

    always_ff @(posedge clk) begin
        if (rst)                             rts <= 1'b1;
        else if (fifo_count >= CNT_W'(RTS_OFF)) rts <= 1'b0;
        else if (fifo_count <  CNT_W'(RTS_ON))  rts <= 1'b1;
    end

endmodule

// File: rtl/urx_checks.sv
module urx_checks #(
    parameter int DEPTH   = 32,
    parameter int RTS_OFF = 28,
    parameter int RTS_ON  = 24,
    parameter int N_MATCH = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_en,
    input logic [CW-1:0]      fifo_count,
    input logic               fifo_empty,
    input logic               rts,
    input logic [N_MATCH-1:0] match_hit,
    input logic [N_MATCH-1:0] cfg_match_en
);
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == $past(fifo_count)) ||
        (fifo_count == $past(fifo_count) + CW'(1)) ||
        (fifo_count == $past(fifo_count) - CW'(1)));

    p_rts_off_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_count >= CW'(RTS_OFF)) |=> !rts);

    p_rts_on_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_count < CW'(RTS_ON)) |=> rts);

    p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && rd_en) |=> (fifo_count <= CW'(1)));

    p_hit_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        (|match_hit) |-> ((match_hit & ~$past(cfg_match_en)) == '0));

    p_hit_stored_r10: assert property (@(posedge clk) disable iff (rst)
        (|match_hit) |-> (fifo_count != '0));

endmodule

bind uart_rx_top urx_checks #(
    .DEPTH(DEPTH), .RTS_OFF(RTS_OFF), .RTS_ON(RTS_ON), .N_MATCH(N_MATCH)
) u_checks (
    .clk(clk), .rst(rst), .rd_en(rd_en), .fifo_count(fifo_count),
    .fifo_empty(fifo_empty), .rts(rts), .match_hit(match_hit),
    .cfg_match_en(cfg_match_en)
);

// File: tb/tb_uart_rx_top.sv
module tb_uart_rx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        tick16 = 1'b0;
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_par = 2'd0;
    logic        cfg_stop2 = 1'b0;
    logic [15:0] cfg_cgap = 16'd40;
    logic [15:0] cfg_bgap = 16'd400;
    logic [3:0]  cfg_match_en = 4'hF;
    logic [31:0] cfg_match_val = {8'h81, 8'h7E, 8'h3C, 8'hA5};
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_perr, rd_ferr, fifo_empty, rts, char_gap, buf_gap;
    logic [5:0]  fifo_count;
    logic [3:0]  match_hit;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit m_rts = 1;
    logic [3:0] hits_seen = '0;
    bit [9:0] q[$];

    uart_rx_top dut (
        .clk(clk), .rst(rst), .rxd(rxd), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .cfg_cgap(cfg_cgap), .cfg_bgap(cfg_bgap),
        .cfg_match_en(cfg_match_en), .cfg_match_val(cfg_match_val),
        .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .fifo_empty(fifo_empty), .fifo_count(fifo_count), .rts(rts),
        .char_gap(char_gap), .buf_gap(buf_gap), .match_hit(match_hit)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-clock comparison against the behavioural flow-control model
    always @(negedge clk) begin
        hits_seen = hits_seen | match_hit;
        if (rst) begin
            m_rts = 1;
        end else begin
            chk(rts == m_rts, "R7 rts", rts, m_rts);
            chk(fifo_empty == (fifo_count == 0), "R6 empty flag", fifo_empty, fifo_count == 0);
            if (fifo_count >= 28) m_rts = 0;
            else if (fifo_count < 24) m_rts = 1;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
    endtask

    task automatic set_line(input bit v);
        @(negedge clk);
        rxd = v;
    endtask

    task automatic send(input bit [7:0] d, input int nb, input int par,
                        input bit st2, input bit flip_par, input bit bad_stop);
        bit [7:0] md;
        bit pb;
        md = d & 8'((1 << nb) - 1);
        set_line(0); wait_ticks(16);
        for (int i = 0; i < nb; i++) begin
            set_line(md[i]); wait_ticks(16);
        end
        if (par != 0) begin
            pb = (par == 2) ? ^md : ~^md;
            set_line(pb ^ flip_par); wait_ticks(16);
        end
        if (st2) begin
            set_line(1); wait_ticks(16);
        end
        set_line(!bad_stop); wait_ticks(16);
        set_line(1); wait_ticks(2);
        if (q.size() < 32) q.push_back({md, (par != 0) && flip_par, bad_stop});
    endtask

    task automatic pop_check(input string req);
        bit [9:0] e;
        e = q.pop_front();
        @(negedge clk);
        chk({rd_data, rd_perr, rd_ferr} == e, req, {rd_data, rd_perr, rd_ferr}, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fifo_empty == 1 && fifo_count == 0, "R1 empty after reset", fifo_count, 0);
        chk(rts == 1, "R1 rts after reset", rts, 1);
        chk({char_gap, buf_gap, match_hit} == 0, "R1 flags after reset",
            {char_gap, buf_gap, match_hit}, 0);

        // R11: pop on empty
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        chk(fifo_count == 0 && fifo_empty, "R11 pop when empty", fifo_count, 0);

        // R3 / R10: 8-bit frame matching comparator 0
        hits_seen = '0;
        send(8'hA5, 8, 0, 0, 0, 0);
        chk(fifo_count == q.size(), "R6 count", fifo_count, q.size());
        chk(hits_seen == 4'b0001, "R10 hit comp0", hits_seen, 4'b0001);
        pop_check("R3 8-bit data");

        // R2: short low pulse rejected
        set_line(0); wait_ticks(5); set_line(1); wait_ticks(40);
        chk(fifo_count == 0, "R2 glitch rejected", fifo_count, 0);

        // R3: shorter characters
        cfg_len = 2'd0;
        send(8'hFB, 5, 0, 0, 0, 0);
        cfg_len = 2'd2;
        send(8'hD5, 7, 0, 0, 0, 0);
        chk(fifo_count == 2, "R3 count", fifo_count, 2);
        pop_check("R3 5-bit data");
        pop_check("R3 7-bit data");

        // R4: parity
        cfg_len = 2'd3; cfg_par = 2'd2;
        send(8'h37, 8, 2, 0, 0, 0);
        send(8'h37, 8, 2, 0, 1, 0);
        cfg_par = 2'd1;
        send(8'h6C, 8, 1, 0, 0, 0);
        send(8'h6C, 8, 1, 0, 1, 0);
        pop_check("R4 even ok");
        pop_check("R4 even bad");
        pop_check("R4 odd ok");
        pop_check("R4 odd bad");

        // R5: stop bits
        cfg_par = 2'd0;
        hits_seen = '0;
        send(8'hA5, 8, 0, 0, 0, 1);
        wait_ticks(20);
        chk(hits_seen == 0, "R10 no hit on framing error", hits_seen, 0);
        cfg_stop2 = 1'b1;
        send(8'h42, 8, 0, 1, 0, 0);
        send(8'h43, 8, 0, 1, 0, 1);
        cfg_stop2 = 1'b0;
        chk(fifo_count == 3, "R5 stored with errors", fifo_count, 3);
        pop_check("R5 one stop low");
        pop_check("R5 two stops ok");
        pop_check("R5 second stop low");

        // R10: enable gating and other comparators
        cfg_match_en = 4'b1101;
        hits_seen = '0;
        send(8'h3C, 8, 0, 0, 0, 0);
        chk(hits_seen == 0, "R10 disabled comp", hits_seen, 0);
        cfg_match_en = 4'hF;
        hits_seen = '0;
        send(8'h81, 8, 0, 0, 0, 0);
        chk(hits_seen == 4'b1000, "R10 hit comp3", hits_seen, 4'b1000);
        pop_check("R10 data");
        pop_check("R10 data");

        // R8 / R9: gap timers
        wait_ticks(450);
        chk(buf_gap == 1, "R9 buffer elapsed", buf_gap, 1);
        send(8'h11, 8, 0, 0, 0, 0);
        chk(buf_gap == 0 && char_gap == 0, "R8 R9 cleared on char", {char_gap, buf_gap}, 0);
        wait_ticks(50);
        chk(char_gap == 1, "R8 idle gap", char_gap, 1);
        chk(buf_gap == 0, "R9 not yet", buf_gap, 0);
        wait_ticks(400);
        send(8'h12, 8, 0, 0, 0, 0);
        wait_ticks(200);
        send(8'h13, 8, 0, 0, 0, 0);
        chk(buf_gap == 0, "R9 open buffer", buf_gap, 0);
        wait_ticks(60);
        chk(buf_gap == 1, "R9 no restart within buffer", buf_gap, 1);
        chk(char_gap == 1, "R8 after second char", char_gap, 1);
        pop_check("R8 data");
        pop_check("R9 data");
        pop_check("R9 data");

        // R6 / R7: fill, overflow, hysteresis
        cfg_match_en = 4'h0;
        for (int i = 0; i < 34; i++) begin
            send(8'(i + 1), 8, 0, 0, 0, 0);
            if (i == 26) chk(rts == 1, "R7 rts at 27", rts, 1);
            if (i == 27) chk(rts == 0, "R7 rts at 28", rts, 0);
        end
        chk(fifo_count == 32, "R6 full drop", fifo_count, 32);
        for (int i = 0; i < 8; i++) pop_check("R6 order");
        repeat (2) @(negedge clk);
        chk(rts == 0, "R7 hold at 24", rts, 0);
        pop_check("R6 order");
        repeat (2) @(negedge clk);
        chk(rts == 1, "R7 on below 24", rts, 1);
        while (q.size() > 0) pop_check("R6 order");
        chk(fifo_empty == 1, "R6 drained", fifo_empty, 1);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        chk(fifo_count == 0, "R11 no wrap", fifo_count, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule